// File: doc/BRIEF.md
# Sixteen-bit ALU with status register

This block is the arithmetic and logic stage of a small processor core together with the status register that records the outcome. Two operands and an opcode go in; the result comes out combinationally in the same cycle, together with a write-enable that tells the register file whether the destination should be written. When the operation is strobed with `exec_i`, the carry, zero, negative and overflow flags are loaded into the status register at the next rising clock edge. Whether flags are loaded depends on the opcode: data moves and branch-target additions leave the whole status register as it was.

Subtraction follows the inverted-borrow convention. The stored carry is 1 when the subtraction needed no borrow and 0 when it did. The same bit is consumed as "not borrow" by subtract-with-carry. The status register also holds three control bits: global interrupt enable, a processor-off request and an oscillator-off request. The ALU never changes these bits. A direct write port loads the whole register.

Top module: `alu_status_unit`

## Requirements
- R1: ADD (opcode 1) gives result = (A + B) mod 2^16. When strobed, it loads C with the unsigned carry-out and V with the signed two's-complement overflow. Example: 0x9A4F + 0xC3D0 gives 0x5E1F with C=1 and V=1.
- R2: ADDC (opcode 2) gives result = (A + B + C) mod 2^16, where C is the stored carry. Its flags follow the rules of R1.
- R3: SUB (opcode 3) gives result = (A − B) mod 2^16. C=1 when A ≥ B unsigned (no borrow) and C=0 otherwise. V is the signed overflow of A − B.
- R4: SUBC (opcode 4) gives result = A − B − (1 − C), where C is the stored carry. C is set when no borrow occurs and V is the signed overflow.
- R5: CMP (opcode 5) loads the flags exactly as SUB would, and holds `res_we_o` low.
- R6: For every flag-loading operation, N equals result bit 15 and Z is 1 exactly when the result is zero.
- R7: AND, OR and XOR (opcodes 6, 7 and 8) give the bitwise result, clear C and V, and set N and Z from the result.
- R8: MOV (opcode 0, result = B), BRADD (opcode 9, result = A + B) and the undefined opcodes 10 to 15 leave every status-register bit unchanged. Undefined opcodes drive result 0.
- R9: The result is combinational. The flags change only at the rising edge after a cycle with `exec_i` high. With `exec_i` and `sr_we_i` both low, the status register holds its value.
- R10: When `sr_we_i` is high, the status register loads `sr_wdata_i` at the next edge. This write takes priority over a concurrent ALU flag update. Bit layout: 0 C, 1 Z, 2 N, 3 V, 4 GIE, 5 CPUOFF, 6 OSCOFF.
- R11: Reset clears the whole status register. ALU operations never change GIE, CPUOFF or OSCOFF.
- R12: `res_we_o` equals `exec_i` for opcodes 0–4 and 6–9, and is low for CMP and for the undefined opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Operation strobe |
| op_i | input | 4 | Opcode |
| a_i | input | 16 | Operand A (destination / minuend) |
| b_i | input | 16 | Operand B (source / subtrahend) |
| sr_we_i | input | 1 | Direct status-register write |
| sr_wdata_i | input | 7 | Status-register write data |
| result_o | output | 16 | Combinational result |
| res_we_o | output | 1 | Destination write enable |
| c_o | output | 1 | Stored carry / not-borrow |
| z_o | output | 1 | Stored zero flag |
| n_o | output | 1 | Stored negative flag |
| v_o | output | 1 | Stored overflow flag |
| gie_o | output | 1 | Global interrupt enable bit |
| cpu_off_o | output | 1 | Processor-off request bit |
| osc_off_o | output | 1 | Oscillator-off request bit |
| sr_o | output | 7 | Full status register |

## Verification
Addition is exercised with two negative operands that overflow into a positive sum, with mixed signs that carry out without overflow, and with 0xFFFF + 1. Together these separate the unsigned carry, the signed overflow and the zero flag.

Subtraction and compare are run with A greater than, equal to and less than B, and with 0x8000 − 1. These cases separate the inverted-borrow carry from a plain borrow bit and expose an overflow computed with the wrong sign test. The carry-consuming operations are each run with the stored carry first 0 and then 1, which catches a carry-in that is ignored or inverted.

Flag preservation is tested after preloading distinctive flag patterns, so that a move, a branch-target add or an undefined opcode that wrongly writes the flags is visible at the ports.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DW  = 16;
  localparam int OPW = 4;
  localparam int SRW = 7;

  localparam int SR_C      = 0;
  localparam int SR_Z      = 1;
  localparam int SR_N      = 2;
  localparam int SR_V      = 3;
  localparam int SR_GIE    = 4;
  localparam int SR_CPUOFF = 5;
  localparam int SR_OSCOFF = 6;

  typedef enum logic [OPW-1:0] {
    OP_MOV   = 4'd0,
    OP_ADD   = 4'd1,
    OP_ADDC  = 4'd2,
    OP_SUB   = 4'd3,
    OP_SUBC  = 4'd4,
    OP_CMP   = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_XOR   = 4'd8,
    OP_BRADD = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o,
  output logic          ovf_o
);
  logic [DW-1:0] b_eff;
  logic [DW:0]   total;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    total  = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin_i};
    sum_o  = total[DW-1:0];
    cout_o = total[DW];
    ovf_o  = (a_i[DW-1] == b_eff[DW-1]) && (total[DW-1] != a_i[DW-1]);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic_sel_e    sel_i,
  output logic [DW-1:0] res_o
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    always_comb begin
      case (sel_i)
        LG_AND:  res_o[i] = a_i[i] & b_i[i];
        LG_OR:   res_o[i] = a_i[i] | b_i[i];
        LG_XOR:  res_o[i] = a_i[i] ^ b_i[i];
        default: res_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/alu_sr_reg.sv
module alu_sr_reg
  import alu_pkg::*;
#(
  parameter int SRW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sr_we_i,
  input  logic [SRW-1:0] sr_wdata_i,
  input  logic           flag_we_i,
  input  flags_t         flags_i,
  output logic [SRW-1:0] sr_q_o
);
  logic [SRW-1:0] sr_d;
  logic [SRW-1:0] sr_q;
  logic           sr_en;

  always_comb begin
    sr_d  = sr_q;
    sr_en = sr_we_i | flag_we_i;
    if (sr_we_i) begin
      sr_d = sr_wdata_i;
    end else if (flag_we_i) begin
      sr_d[SR_C] = flags_i.c;
      sr_d[SR_Z] = flags_i.z;
      sr_d[SR_N] = flags_i.n;
      sr_d[SR_V] = flags_i.v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  assign sr_q_o = sr_q;
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_pkg::*;
#(
  parameter int DW  = alu_pkg::DW,
  parameter int OPW = alu_pkg::OPW,
  parameter int SRW = alu_pkg::SRW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exec_i,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic           sr_we_i,
  input  logic [SRW-1:0] sr_wdata_i,
  output logic [DW-1:0]  result_o,
  output logic           res_we_o,
  output logic           c_o,
  output logic           z_o,
  output logic           n_o,
  output logic           v_o,
  output logic           gie_o,
  output logic           cpu_off_o,
  output logic           osc_off_o,
  output logic [SRW-1:0] sr_o
);
  localparam int MSB = DW - 1;

  logic [SRW-1:0] sr_q;
  logic           sub_sel;
  logic           cin_sel;
  logic           is_logic;
  logic           op_flags;
  logic           op_wr;
  logic_sel_e     lsel;
  logic [DW-1:0]  as_sum;
  logic           as_cout;
  logic           as_ovf;
  logic [DW-1:0]  lg_res;
  logic [DW-1:0]  res_mux;
  flags_t         flags_new;

  always_comb begin
    sub_sel  = 1'b0;
    cin_sel  = 1'b0;
    is_logic = 1'b0;
    op_flags = 1'b0;
    op_wr    = 1'b0;
    lsel     = LG_AND;
    res_mux  = '0;
    case (op_i)
      OP_MOV:   begin op_wr = 1'b1; res_mux = b_i; end
      OP_ADD:   begin op_wr = 1'b1; op_flags = 1'b1; res_mux = as_sum; end
      OP_ADDC:  begin op_wr = 1'b1; op_flags = 1'b1; cin_sel = sr_q[SR_C]; res_mux = as_sum; end
      OP_SUB:   begin op_wr = 1'b1; op_flags = 1'b1; sub_sel = 1'b1; cin_sel = 1'b1; res_mux = as_sum; end
      OP_SUBC:  begin op_wr = 1'b1; op_flags = 1'b1; sub_sel = 1'b1; cin_sel = sr_q[SR_C]; res_mux = as_sum; end
      OP_CMP:   begin op_flags = 1'b1; sub_sel = 1'b1; cin_sel = 1'b1; res_mux = as_sum; end
      OP_AND:   begin op_wr = 1'b1; op_flags = 1'b1; is_logic = 1'b1; lsel = LG_AND; res_mux = lg_res; end
      OP_OR:    begin op_wr = 1'b1; op_flags = 1'b1; is_logic = 1'b1; lsel = LG_OR;  res_mux = lg_res; end
      OP_XOR:   begin op_wr = 1'b1; op_flags = 1'b1; is_logic = 1'b1; lsel = LG_XOR; res_mux = lg_res; end
      OP_BRADD: begin op_wr = 1'b1; res_mux = as_sum; end
      default:  begin res_mux = '0; end
    endcase
  end

  alu_addsub #(.DW(DW)) addsub_i (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (sub_sel),
    .cin_i  (cin_sel),
    .sum_o  (as_sum),
    .cout_o (as_cout),
    .ovf_o  (as_ovf)
  );

  alu_logic #(.DW(DW)) logic_i (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (lsel),
    .res_o (lg_res)
  );

  always_comb begin
    flags_new.z = (res_mux == '0);
    flags_new.n = res_mux[MSB];
    flags_new.c = is_logic ? 1'b0 : as_cout;
    flags_new.v = is_logic ? 1'b0 : as_ovf;
  end

  alu_sr_reg #(.SRW(SRW)) sr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sr_we_i    (sr_we_i),
    .sr_wdata_i (sr_wdata_i),
    .flag_we_i  (exec_i & op_flags),
    .flags_i    (flags_new),
    .sr_q_o     (sr_q)
  );

  assign result_o  = res_mux;
  assign res_we_o  = exec_i & op_wr;
  assign c_o       = sr_q[SR_C];
  assign z_o       = sr_q[SR_Z];
  assign n_o       = sr_q[SR_N];
  assign v_o       = sr_q[SR_V];
  assign gie_o     = sr_q[SR_GIE];
  assign cpu_off_o = sr_q[SR_CPUOFF];
  assign osc_off_o = sr_q[SR_OSCOFF];
  assign sr_o      = sr_q;
endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk
  import alu_pkg::*;
#(
  parameter int DW  = alu_pkg::DW,
  parameter int OPW = alu_pkg::OPW,
  parameter int SRW = alu_pkg::SRW
) (
  input logic           clk,
  input logic           rst_n,
  input logic           exec_i,
  input logic [OPW-1:0] op_i,
  input logic           sr_we_i,
  input logic [SRW-1:0] sr_wdata_i,
  input logic [DW-1:0]  result_o,
  input logic           res_we_o,
  input logic [SRW-1:0] sr_o
);
  logic flag_op;
  logic logic_op;
  assign flag_op  = (op_i >= OP_ADD) && (op_i <= OP_XOR);
  assign logic_op = (op_i >= OP_AND) && (op_i <= OP_XOR);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_i && !sr_we_i) |=> $stable(sr_o));

  p_sr_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we_i |=> (sr_o == $past(sr_wdata_i)));

  p_cmp_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_CMP) |-> !res_we_o);

  p_noflag_ops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !sr_we_i && (op_i == OP_MOV || op_i >= OP_BRADD)) |=> $stable(sr_o));

  p_zn_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !sr_we_i && flag_op) |=>
      (sr_o[SR_Z] == ($past(result_o) == '0)) && (sr_o[SR_N] == $past(result_o[DW-1])));

  p_logic_cv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !sr_we_i && logic_op) |=> (!sr_o[SR_C] && !sr_o[SR_V]));

  p_ctrl_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_we_i |=> $stable(sr_o[SRW-1:SR_GIE]));

  p_nowrite_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |-> !res_we_o);
endmodule

bind alu_status_unit alu_status_chk #(.DW(DW), .OPW(OPW), .SRW(SRW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .exec_i     (exec_i),
  .op_i       (op_i),
  .sr_we_i    (sr_we_i),
  .sr_wdata_i (sr_wdata_i),
  .result_o   (result_o),
  .res_we_o   (res_we_o),
  .sr_o       (sr_o)
);

// File: tb/alu_status_unit_tb_top.sv
module alu_status_unit_tb_top;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        exec_i;
  logic [3:0]  op_i;
  logic [15:0] a_i;
  logic [15:0] b_i;
  logic        sr_we_i;
  logic [6:0]  sr_wdata_i;
  logic [15:0] result_o;
  logic        res_we_o;
  logic        c_o, z_o, n_o, v_o, gie_o, cpu_off_o, osc_off_o;
  logic [6:0]  sr_o;

  int n_chk;
  int n_fail;
  logic [6:0] exp_sr;

  alu_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .sr_we_i(sr_we_i), .sr_wdata_i(sr_wdata_i), .result_o(result_o), .res_we_o(res_we_o),
    .c_o(c_o), .z_o(z_o), .n_o(n_o), .v_o(v_o), .gie_o(gie_o), .cpu_off_o(cpu_off_o),
    .osc_off_o(osc_off_o), .sr_o(sr_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  // Bench-side reference: opcode meaning taken from the requirements.
  task automatic ref_op(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                        output logic [15:0] r, output logic we, output logic fw,
                        output logic [3:0] cznv);
    int ua, ub, sa, sb, s, ss, bin;
    logic c, v;
    ua = int'(a); ub = int'(b);
    sa = int'($signed(a)); sb = int'($signed(b));
    c = 1'b0; v = 1'b0; r = 16'h0; we = 1'b1; fw = 1'b1;
    case (op)
      4'd0: begin r = b; fw = 1'b0; end
      4'd1, 4'd2: begin
        bin = (op == 4'd2) ? int'(exp_sr[0]) : 0;
        s = ua + ub + bin; ss = sa + sb + bin;
        r = s[15:0]; c = (s > 65535); v = (ss > 32767) || (ss < -32768);
      end
      4'd3, 4'd4, 4'd5: begin
        bin = (op == 4'd4) ? (1 - int'(exp_sr[0])) : 0;
        s = ua - ub - bin; ss = sa - sb - bin;
        r = s[15:0]; c = (ua >= ub + bin); v = (ss > 32767) || (ss < -32768);
        if (op == 4'd5) we = 1'b0;
      end
      4'd6: r = a & b;
      4'd7: r = a | b;
      4'd8: r = a ^ b;
      4'd9: begin s = ua + ub; r = s[15:0]; fw = 1'b0; end
      default: begin r = 16'h0; we = 1'b0; fw = 1'b0; end
    endcase
    cznv = {c, (r == 16'h0), r[15], v};
  endtask

  // Drive one strobed operation and check result, write enable and flags.
  task automatic run_op(input string req, input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] r; logic we, fw; logic [3:0] cznv;
    ref_op(op, a, b, r, we, fw, cznv);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; exec_i = 1'b1;
    #1;
    if (we) check(req, "result", 32'(result_o), 32'(r));
    check("R12", "res_we", 32'(res_we_o), 32'(we));
    @(posedge clk);
    #1;
    exec_i = 1'b0;
    if (fw) begin
      exp_sr[0] = cznv[3]; exp_sr[1] = cznv[2]; exp_sr[2] = cznv[1]; exp_sr[3] = cznv[0];
    end
    check(req, "sr", 32'(sr_o), 32'(exp_sr));
    check(req, "flag pins", 32'({c_o, z_o, n_o, v_o}), 32'({exp_sr[0], exp_sr[1], exp_sr[2], exp_sr[3]}));
  endtask

  task automatic write_sr(input logic [6:0] val);
    @(negedge clk);
    sr_we_i = 1'b1; sr_wdata_i = val;
    @(posedge clk);
    #1;
    sr_we_i = 1'b0;
    exp_sr = val;
    check("R10", "sr after write", 32'(sr_o), 32'(val));
  endtask

  task automatic t_reset();
    check("R11", "sr at reset", 32'(sr_o), 32'h0);
    check("R11", "ctrl pins at reset", 32'({gie_o, cpu_off_o, osc_off_o}), 32'h0);
    check("R12", "res_we idle", 32'(res_we_o), 32'h0);
  endtask

  task automatic t_add();
    run_op("R1", 4'd1, 16'h9A4F, 16'hC3D0);
    check("R1", "C V neg+neg", 32'({c_o, v_o}), 32'b11);
    run_op("R1", 4'd1, 16'hD54A, 16'h5FA8);
    check("R1", "C V mixed", 32'({c_o, v_o}), 32'b10);
    run_op("R6", 4'd1, 16'hFFFF, 16'h0001);
    check("R6", "Z on wrap", 32'(z_o), 32'h1);
    run_op("R1", 4'd1, 16'h7FFF, 16'h0001);
    check("R6", "N on 0x8000", 32'(n_o), 32'h1);
  endtask

  task automatic t_addc();
    write_sr(7'h00);
    run_op("R2", 4'd2, 16'h1234, 16'h0001);
    write_sr(7'h01);
    run_op("R2", 4'd2, 16'h1234, 16'h0001);
    run_op("R2", 4'd2, 16'hFFFF, 16'h0000);
  endtask

  task automatic t_sub();
    run_op("R3", 4'd3, 16'h0005, 16'h0003);
    check("R3", "no borrow C", 32'(c_o), 32'h1);
    run_op("R3", 4'd3, 16'h0003, 16'h0005);
    check("R3", "borrow C", 32'(c_o), 32'h0);
    run_op("R3", 4'd3, 16'h4444, 16'h4444);
    run_op("R3", 4'd3, 16'h8000, 16'h0001);
    check("R3", "V on 0x8000-1", 32'(v_o), 32'h1);
  endtask

  task automatic t_subc();
    write_sr(7'h00);
    run_op("R4", 4'd4, 16'h0010, 16'h0003);
    write_sr(7'h01);
    run_op("R4", 4'd4, 16'h0010, 16'h0003);
    write_sr(7'h00);
    run_op("R4", 4'd4, 16'h0003, 16'h0003);
  endtask

  task automatic t_cmp();
    run_op("R5", 4'd5, 16'h2000, 16'h2000);
    run_op("R5", 4'd5, 16'h0001, 16'h2000);
    run_op("R5", 4'd5, 16'h8000, 16'h7FFF);
  endtask

  task automatic t_logic();
    write_sr(7'h0F);
    run_op("R7", 4'd6, 16'hF0F0, 16'h0F0F);
    run_op("R7", 4'd7, 16'h8001, 16'h0100);
    run_op("R7", 4'd8, 16'hA5A5, 16'h5A5A);
  endtask

  task automatic t_noflag();
    write_sr(7'h0B);
    run_op("R8", 4'd0, 16'h1111, 16'h0000);
    run_op("R8", 4'd9, 16'hFFFF, 16'h0001);
    for (int k = 10; k < 16; k++) run_op("R8", 4'(k), 16'h8000, 16'h8000);
    write_sr(7'h04);
    run_op("R8", 4'd9, 16'h8000, 16'h8000);
  endtask

  task automatic t_idle();
    write_sr(7'h05);
    @(negedge clk);
    op_i = 4'd1; a_i = 16'hFFFF; b_i = 16'hFFFF; exec_i = 1'b0;
    #1;
    check("R9", "result combinational", 32'(result_o), 32'hFFFE);
    check("R12", "res_we low w/o exec", 32'(res_we_o), 32'h0);
    repeat (3) @(posedge clk);
    #1;
    check("R9", "sr held without exec", 32'(sr_o), 32'(exp_sr));
  endtask

  task automatic t_priority();
    write_sr(7'h00);
    @(negedge clk);
    op_i = 4'd1; a_i = 16'hFFFF; b_i = 16'h0001; exec_i = 1'b1;
    sr_we_i = 1'b1; sr_wdata_i = 7'h48;
    @(posedge clk);
    #1;
    exec_i = 1'b0; sr_we_i = 1'b0;
    exp_sr = 7'h48;
    check("R10", "write beats flag update", 32'(sr_o), 32'h48);
  endtask

  task automatic t_ctrl();
    write_sr(7'h70);
    check("R10", "ctrl pins", 32'({gie_o, cpu_off_o, osc_off_o}), 32'b111);
    run_op("R11", 4'd3, 16'h0000, 16'h0001);
    run_op("R11", 4'd6, 16'h0000, 16'hFFFF);
    check("R11", "ctrl kept", 32'({gie_o, cpu_off_o, osc_off_o}), 32'b111);
    write_sr(7'h20);
    run_op("R11", 4'd1, 16'h0001, 16'h0001);
    check("R11", "cpu_off alone kept", 32'({gie_o, cpu_off_o, osc_off_o}), 32'b010);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; exp_sr = 7'h0;
    rst_n = 1'b0; exec_i = 1'b0; op_i = 4'd0; a_i = '0; b_i = '0;
    sr_we_i = 1'b0; sr_wdata_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_add();
    t_addc();
    t_sub();
    t_subc();
    t_cmp();
    t_logic();
    t_noflag();
    t_idle();
    t_priority();
    t_ctrl();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule